// File: doc/BRIEF.md
# Read-Clear Interrupt Request Controller

This block gathers event pulses from nine sources into one active-high interrupt request. A separate bit in an interrupt status register stands for each source. Typical sources are an external trigger, the end of history recording, a fault condition and a hardware fault. A source's bit is set on the rising edge of its input and stays set until software reads the register. An enable mask decides which of the latched bits may raise the request line.

Software services the interrupt with a single read of the status register. That read returns the latched bits, clears exactly those bits and drops the request line. No separate acknowledge cycle is needed. An event that arrives during the read is not lost. Its bit survives the clear, and the request rises again shortly after.

The request line is driven by a two-state machine:
- `REQ_IDLE`: the line is low.
- `REQ_RAISED`: the line is high.

It has three transitions:
- T_RAISE (`REQ_IDLE` to `REQ_RAISED`): an enabled bit is pending and no status read is in progress.
- T_RELEASE (`REQ_RAISED` to `REQ_IDLE`): a status read occurs.
- T_WITHDRAW (`REQ_RAISED` to `REQ_IDLE`): no enabled bit remains pending, for example because the mask changed.

Top module: `rora_irq_ctrl`

## Requirements
- R1: After reset, the status bits, the enable mask and the request line are all zero.
- R2: A 0-to-1 transition on a source input sets that source's status bit, and the bit is visible one clock later. This happens whether or not the source is enabled. A level that is held high does not set the bit again after a clear.
- R3: The request line goes high two clocks after an enabled source's rising edge. It stays low while only disabled bits are set.
- R4: During a status read, the read data shows the current status bits (bit i is source i). The read clears exactly those bits at the end of the cycle.
- R5: The request line is low in the cycle after a status read.
- R6: An event whose edge falls in the same cycle as a status read keeps its bit set. If that source is enabled, the request line is low one clock after the read and high again two clocks after it.
- R7: Writing the enable mask never changes the status bits. Mask bit i enables source i.
- R8: Clearing the enable of the only pending source drops the request line two clocks after the write. Re-enabling it raises the line again two clocks after that write.
- R9: The request line is the OR over all sources of status AND enable, for any combination of sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 9 | Event inputs, one per source; rising edge is captured |
| mask_we | input | 1 | Enable-mask write strobe |
| mask_wdata | input | 9 | New enable mask, bit i enables source i |
| stat_rd | input | 1 | Status read strobe; clears the returned bits |
| stat_data | output | 9 | Current status bits (read data) |
| irq | output | 1 | Interrupt request, active high |

## Verification
Each result has a fixed latency:
- A status bit appears one clock after its source's edge.
- The request line answers an edge or a mask write two clocks later, because it passes through both the status register and the state register.
- The line falls one clock after a read.

The bench drives inputs on the falling edge and samples outputs on the falling edges that bound those latencies. It checks both the clock before a change and the clock on which the change is due. Read data is sampled in the same falling-edge slot as the read strobe, before the clearing edge.

// File: rtl/rora_pkg.sv
package rora_pkg;

    // States of the request-line machine
    typedef enum logic {
        REQ_IDLE   = 1'b0,
        REQ_RAISED = 1'b1
    } req_state_e;

endpackage

// File: rtl/rora_edge_bank.sv
module rora_edge_bank #(
    parameter int N_SRC = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] lvl_i,
    output logic [N_SRC-1:0] rise_o
);

    logic [N_SRC-1:0] prev_q;

    for (genvar g = 0; g < N_SRC; g++) begin : g_edge
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= lvl_i[g];
        end
        assign rise_o[g] = lvl_i[g] & ~prev_q[g];
    end

endmodule

// File: rtl/rora_status_bank.sv
module rora_status_bank #(
    parameter int N_SRC = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic             clr_rd_i,
    output logic [N_SRC-1:0] bits_o
);

    logic [N_SRC-1:0] bits_q;
    logic [N_SRC-1:0] clr_mask;

    // A read clears only the bits it returns; a new set in the same cycle wins
    assign clr_mask = clr_rd_i ? bits_q : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= (bits_q & ~clr_mask) | set_i;
    end

    assign bits_o = bits_q;

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_rd_i |=> ((bits_q & $past(bits_q)) == $past(bits_q)));

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((bits_q & $past(set_i)) == $past(set_i)));

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rd_i |=> ((bits_q & ~$past(set_i)) == '0));

endmodule

// File: rtl/rora_req_fsm.sv
module rora_req_fsm
    import rora_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    input  logic rd_i,
    output logic req_o
);

    req_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:   if (pending_i && !rd_i) state_d = REQ_RAISED;        // T_RAISE
            REQ_RAISED: if (rd_i || !pending_i) state_d = REQ_IDLE;          // T_RELEASE / T_WITHDRAW
            default:    state_d = REQ_IDLE;
        endcase
    end

    always_comb begin
        req_o = (state_q == REQ_RAISED);
    end

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> !req_o);

    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_i |=> !req_o);

endmodule

// File: rtl/rora_irq_ctrl.sv
module rora_irq_ctrl #(
    parameter int N_SRC = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_evt,
    input  logic             mask_we,
    input  logic [N_SRC-1:0] mask_wdata,
    input  logic             stat_rd,
    output logic [N_SRC-1:0] stat_data,
    output logic             irq
);

    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] status;
    logic [N_SRC-1:0] mask_q;
    logic             pending;

    rora_edge_bank #(.N_SRC(N_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (src_evt),
        .rise_o (rise)
    );

    rora_status_bank #(.N_SRC(N_SRC)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (rise),
        .clr_rd_i (stat_rd),
        .bits_o   (status)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    assign pending = |(status & mask_q);

    rora_req_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .rd_i      (stat_rd),
        .req_o     (irq)
    );

    assign stat_data = status;

    assert_mask_keeps_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && !stat_rd && (rise == '0)) |=> $stable(status));

    assert_mask_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && ((status & mask_wdata) == '0) && (rise == '0) && !stat_rd) |=> ##1 !irq);

endmodule

// File: tb/rora_irq_ctrl_tb.sv
module rora_irq_ctrl_tb;

    localparam int N = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_evt = '0;
    logic         mask_we = 1'b0;
    logic [N-1:0] mask_wdata = '0;
    logic         stat_rd = 1'b0;
    logic [N-1:0] stat_data;
    logic         irq;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    rora_irq_ctrl #(.N_SRC(N)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_evt    (src_evt),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .stat_rd    (stat_rd),
        .stat_data  (stat_data),
        .irq        (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_mask(input logic [N-1:0] m);
        mask_wdata = m;
        mask_we = 1'b1;
        step();
        mask_we = 1'b0;
    endtask

    // Read and clear; checks the returned data in the read cycle
    task automatic do_read(input string req, input logic [N-1:0] exp);
        stat_rd = 1'b1;
        #1;
        chk(req, 32'(stat_data), 32'(exp));
        step();
        stat_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk("R1 status", 32'(stat_data), 0);
        chk("R1 irq", 32'(irq), 0);

        // R1: mask resets to zero, so an event must not raise irq
        src_evt[0] = 1'b1; step(); src_evt[0] = 1'b0; step();
        chk("R1 mask zero irq", 32'(irq), 0);
        do_read("R1 read", 9'h001);

        // R2/R3: each source, disabled then enabled
        for (int i = 0; i < N; i++) begin
            for (int en = 0; en < 2; en++) begin
                set_mask(en ? (9'(1) << i) : '0);
                src_evt[i] = 1'b1;
                step();
                chk("R2 capture", 32'(stat_data), 32'(9'(1) << i));
                chk("R3 irq not yet", 32'(irq), 0);
                src_evt[i] = 1'b0;
                step();
                chk("R3 irq", 32'(irq), 32'(en));
                do_read("R4 read value", 9'(1) << i);
                chk("R4 cleared", 32'(stat_data), 0);
                chk("R5 released", 32'(irq), 0);
            end
        end

        // R2: held level does not re-set after clear
        set_mask('1);
        src_evt[4] = 1'b1; step(); step();
        do_read("R2 held read", 9'h010);
        step(); step();
        chk("R2 held no reset", 32'(stat_data), 0);
        chk("R2 held irq", 32'(irq), 0);
        src_evt[4] = 1'b0; step();

        // R6: event in same cycle as read
        src_evt[0] = 1'b1; step(); src_evt[0] = 1'b0; step();
        chk("R6 pre irq", 32'(irq), 1);
        stat_rd = 1'b1; src_evt[3] = 1'b1;
        #1 chk("R6 read data", 32'(stat_data), 32'h001);
        step();
        stat_rd = 1'b0; src_evt[3] = 1'b0;
        chk("R6 bit kept", 32'(stat_data), 32'h008);
        chk("R6 irq low", 32'(irq), 0);
        step();
        chk("R6 irq reasserts", 32'(irq), 1);
        do_read("R6 clear", 9'h008);

        // R7/R8: mask change on a pending source
        src_evt[2] = 1'b1; step(); src_evt[2] = 1'b0; step();
        chk("R8 irq up", 32'(irq), 1);
        set_mask(9'h1FB);
        chk("R7 status kept", 32'(stat_data), 32'h004);
        chk("R8 irq lags", 32'(irq), 1);
        step();
        chk("R8 irq withdrawn", 32'(irq), 0);
        set_mask('1);
        chk("R7 status kept 2", 32'(stat_data), 32'h004);
        step();
        chk("R8 irq restored", 32'(irq), 1);
        do_read("R8 clear", 9'h004);

        // R9: sweep over all source combinations with varying masks
        for (int p = 0; p < (1 << N); p++) begin
            logic [N-1:0] m;
            logic [N-1:0] pat;
            pat = 9'(p);
            m = 9'((p * 37 + 11) % 512);
            set_mask(m);
            src_evt = pat; step(); src_evt = '0; step();
            chk("R9 status", 32'(stat_data), 32'(pat));
            chk("R9 irq", 32'(irq), 32'(|(pat & m)));
            do_read("R9 read", pat);
            chk("R9 cleared irq", 32'(irq), 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule